// File: doc/BRIEF.md
# Bidirectional Decision-Tree Pipeline Stage

This block is one stage of a linear lookup pipeline that walks a packet-classification decision tree. Nodes from one tree level may sit in different stages, so every packet carries a countdown of the stages it must still pass before its next node is due. A packet also carries the address of that node. When the countdown is nonzero the stage lets the packet through and lowers the count by one. When the countdown is zero the stage reads its local node memory at the carried address. The node it reads supplies the countdown to the child node and the data that the cut logic needs to form the child address.

Two traversal directions are served at once. One lane carries packets that walk the stages in rising order, and the other carries packets that walk them in falling order. Each lane owns one port of a dual-port node memory with synchronous read. An upstream table lookup sets the starting countdown, root address and direction of each packet before it enters. Once a packet reaches a leaf, it carries the leaf's rule-list pointer unchanged to the end of the pipeline. Node entries are loaded through a separate write port. That port borrows whichever memory port is idle in the cycle and acknowledges the write in the same cycle.

Top module: `dtree_stage`

## Requirements
- R1: After reset both lane outputs are invalid. The write acknowledge is low in any cycle with no write request.
- R2: Every lane has a fixed latency of two clock edges. A packet presented at edge k appears at the lane output after edge k+1, whether or not the memory is read. Packets leave in the order they entered.
- R3: A valid non-leaf packet with a nonzero countdown leaves with its countdown lowered by one and its node address unchanged.
- R4: A valid non-leaf packet with a zero countdown reads the node word at its address. The node word has this layout: bit 15 is the leaf flag, bits 14:9 are the base address, bits 8:6 are the cut count for field 1, bits 5:3 are the cut count for field 0, and bits 2:0 are the child countdown. For a non-leaf node the packet leaves with the child countdown and with the child address from R5.
- R5: In the header, field 0 is bits 7:0 and field 1 is bits 15:8. For each field the top n bits are taken, where n is that field's cut count, and these groups are joined with field 0 as the most significant group. A count of zero contributes no bits. The child address is the base address plus this index, modulo 64.
- R6: When the node read is a leaf, the packet leaves with the leaf flag set, the node's base address as its rule-list pointer, and a countdown of zero.
- R7: A packet that already carries the leaf flag passes with its address and countdown unchanged, even with a zero countdown.
- R8: The header and the direction bit leave unchanged in both lanes.
- R9: Both lanes can read the node memory in the same cycle, and each gets the entry at its own address.
- R10: A write request is acknowledged in the same cycle unless both lanes read memory in that cycle. An acknowledged write is visible to any read issued at a later edge.
- R11: An invalid input yields an invalid output two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_fwd_valid | input | 1 | Rising-order lane packet present |
| i_fwd_hdr | input | 16 | Rising-order lane header fields |
| i_fwd_dist | input | 3 | Rising-order lane stage countdown |
| i_fwd_addr | input | 6 | Rising-order lane node address or rule pointer |
| i_fwd_leaf | input | 1 | Rising-order lane leaf reached |
| i_fwd_dir | input | 1 | Rising-order lane direction bit |
| i_rev_valid | input | 1 | Falling-order lane packet present |
| i_rev_hdr | input | 16 | Falling-order lane header fields |
| i_rev_dist | input | 3 | Falling-order lane stage countdown |
| i_rev_addr | input | 6 | Falling-order lane node address or rule pointer |
| i_rev_leaf | input | 1 | Falling-order lane leaf reached |
| i_rev_dir | input | 1 | Falling-order lane direction bit |
| o_fwd_valid | output | 1 | Rising-order lane result present |
| o_fwd_hdr | output | 16 | Rising-order lane header out |
| o_fwd_dist | output | 3 | Rising-order lane next countdown |
| o_fwd_addr | output | 6 | Rising-order lane next address or rule pointer |
| o_fwd_leaf | output | 1 | Rising-order lane leaf flag out |
| o_fwd_dir | output | 1 | Rising-order lane direction out |
| o_rev_valid | output | 1 | Falling-order lane result present |
| o_rev_hdr | output | 16 | Falling-order lane header out |
| o_rev_dist | output | 3 | Falling-order lane next countdown |
| o_rev_addr | output | 6 | Falling-order lane next address or rule pointer |
| o_rev_leaf | output | 1 | Falling-order lane leaf flag out |
| o_rev_dir | output | 1 | Falling-order lane direction out |
| i_wr_en | input | 1 | Node write request |
| i_wr_addr | input | 6 | Node write address |
| i_wr_data | input | 16 | Node word to write |
| o_wr_ack | output | 1 | Write taken this cycle |

## Verification
A corrupted first-stage register shows up at the lane outputs one edge later, two edges after the packet entered, as a wrong countdown, address, header or valid bit. A wrong memory entry shows up only when a packet with a zero countdown addresses that entry. It then appears two edges later as a wrong child address or countdown, so the bench reads back every entry it loads. A fault in the write steering shows in the same cycle on the acknowledge. It can also show later as a read that returns stale data, or as a lane that gets the other lane's entry when both lanes read together.

// File: rtl/dtree_pkg.sv
package dtree_pkg;
   localparam int NUM_LANES = 2;
   localparam int LANE_UP   = 0;
   localparam int LANE_DOWN = 1;

   typedef enum logic {
      WALK_UP   = 1'b0,
      WALK_DOWN = 1'b1
   } walk_dir_e;
endpackage

// File: rtl/dtree_cut.sv
module dtree_cut #(
   parameter int NF      = 2,
   parameter int FIELD_W = 8,
   parameter int CUT_W   = 3,
   parameter int ADDR_W  = 6,
   parameter int HDR_W   = NF * FIELD_W
) (
   input  logic [HDR_W-1:0]    hdr,
   input  logic [NF*CUT_W-1:0] cuts,
   input  logic [ADDR_W-1:0]   base,
   output logic [ADDR_W-1:0]   child
);
   logic [CUT_W-1:0]   cnt [NF];
   logic [FIELD_W-1:0] top [NF];

   for (genvar gi = 0; gi < NF; gi++) begin : g_field
      assign cnt[gi] = cuts[gi*CUT_W +: CUT_W];
      assign top[gi] = hdr[gi*FIELD_W +: FIELD_W] >> (FIELD_W - int'(cnt[gi]));
   end

   logic [ADDR_W-1:0] idx;
   always_comb begin
      idx = '0;
      for (int i = 0; i < NF; i++) begin
         idx = (idx << cnt[i]) | ADDR_W'(top[i]);
      end
   end

   assign child = base + idx;
endmodule

// File: rtl/dtree_dpram.sv
module dtree_dpram #(
   parameter int AW = 6,
   parameter int DW = 16,
   localparam int DEPTH = 1 << AW
) (
   input  logic                clk,
   input  logic [1:0]          we,
   input  logic [1:0]          re,
   input  logic [1:0][AW-1:0]  addr,
   input  logic [DW-1:0]       wdata,
   output logic [1:0][DW-1:0]  rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int p = 0; p < 2; p++) begin
         if (we[p]) begin
            mem[addr[p]] <= wdata;
         end else if (re[p]) begin
            rdata[p] <= mem[addr[p]];
         end
      end
   end
endmodule

// File: rtl/dtree_lane.sv
module dtree_lane #(
   parameter int NF      = 2,
   parameter int FIELD_W = 8,
   parameter int CUT_W   = 3,
   parameter int ADDR_W  = 6,
   parameter int DIST_W  = 3,
   parameter int HDR_W   = NF * FIELD_W,
   parameter int NODE_W  = 1 + ADDR_W + NF * CUT_W + DIST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [HDR_W-1:0]  in_hdr,
   input  logic [DIST_W-1:0] in_dist,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_leaf,
   input  logic              in_dir,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [NODE_W-1:0] rd_node,
   output logic              out_valid,
   output logic [HDR_W-1:0]  out_hdr,
   output logic [DIST_W-1:0] out_dist,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_leaf,
   output logic              out_dir
);
   localparam int CUTS_LSB = DIST_W;
   localparam int BASE_LSB = DIST_W + NF * CUT_W;

   // access request toward the node memory
   assign rd_en   = in_valid & ~in_leaf & (in_dist == '0);
   assign rd_addr = in_addr;

   // first half: hold packet while the memory read completes
   logic              s1_valid, s1_hit, s1_leaf, s1_dir;
   logic [HDR_W-1:0]  s1_hdr;
   logic [DIST_W-1:0] s1_dist;
   logic [ADDR_W-1:0] s1_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_leaf  <= 1'b0;
         s1_dir   <= 1'b0;
         s1_hdr   <= '0;
         s1_dist  <= '0;
         s1_addr  <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_hit   <= rd_en;
         s1_leaf  <= in_leaf;
         s1_dir   <= in_dir;
         s1_hdr   <= in_hdr;
         s1_dist  <= in_dist;
         s1_addr  <= in_addr;
      end
   end

   // node decode
   logic                 nd_leaf;
   logic [ADDR_W-1:0]    nd_base;
   logic [NF*CUT_W-1:0]  nd_cuts;
   logic [DIST_W-1:0]    nd_dist;
   logic [ADDR_W-1:0]    child;

   assign nd_leaf = rd_node[NODE_W-1];
   assign nd_base = rd_node[BASE_LSB +: ADDR_W];
   assign nd_cuts = rd_node[CUTS_LSB +: NF*CUT_W];
   assign nd_dist = rd_node[DIST_W-1:0];

   dtree_cut #(
      .NF(NF), .FIELD_W(FIELD_W), .CUT_W(CUT_W), .ADDR_W(ADDR_W), .HDR_W(HDR_W)
   ) u_cut (
      .hdr   (s1_hdr),
      .cuts  (nd_cuts),
      .base  (nd_base),
      .child (child)
   );

   logic [DIST_W-1:0] nx_dist;
   logic [ADDR_W-1:0] nx_addr;
   logic              nx_leaf;

   always_comb begin
      nx_dist = s1_dist;
      nx_addr = s1_addr;
      nx_leaf = s1_leaf;
      if (s1_hit) begin
         nx_leaf = nd_leaf;
         nx_addr = nd_leaf ? nd_base : child;
         nx_dist = nd_leaf ? '0 : nd_dist;
      end else if (!s1_leaf && s1_dist != '0) begin
         nx_dist = s1_dist - DIST_W'(1);
      end
   end

   // second half: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hdr   <= '0;
         out_dist  <= '0;
         out_addr  <= '0;
         out_leaf  <= 1'b0;
         out_dir   <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         out_hdr   <= s1_hdr;
         out_dist  <= nx_dist;
         out_addr  <= nx_addr;
         out_leaf  <= nx_leaf;
         out_dir   <= s1_dir;
      end
   end
endmodule

// File: rtl/dtree_stage.sv
module dtree_stage
   import dtree_pkg::*;
#(
   parameter int NF      = 2,
   parameter int FIELD_W = 8,
   parameter int CUT_W   = 3,
   parameter int ADDR_W  = 6,
   parameter int DIST_W  = 3,
   parameter int HDR_W   = NF * FIELD_W,
   parameter int NODE_W  = 1 + ADDR_W + NF * CUT_W + DIST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_fwd_valid,
   input  logic [HDR_W-1:0]  i_fwd_hdr,
   input  logic [DIST_W-1:0] i_fwd_dist,
   input  logic [ADDR_W-1:0] i_fwd_addr,
   input  logic              i_fwd_leaf,
   input  logic              i_fwd_dir,
   input  logic              i_rev_valid,
   input  logic [HDR_W-1:0]  i_rev_hdr,
   input  logic [DIST_W-1:0] i_rev_dist,
   input  logic [ADDR_W-1:0] i_rev_addr,
   input  logic              i_rev_leaf,
   input  logic              i_rev_dir,
   output logic              o_fwd_valid,
   output logic [HDR_W-1:0]  o_fwd_hdr,
   output logic [DIST_W-1:0] o_fwd_dist,
   output logic [ADDR_W-1:0] o_fwd_addr,
   output logic              o_fwd_leaf,
   output logic              o_fwd_dir,
   output logic              o_rev_valid,
   output logic [HDR_W-1:0]  o_rev_hdr,
   output logic [DIST_W-1:0] o_rev_dist,
   output logic [ADDR_W-1:0] o_rev_addr,
   output logic              o_rev_leaf,
   output logic              o_rev_dir,
   input  logic              i_wr_en,
   input  logic [ADDR_W-1:0] i_wr_addr,
   input  logic [NODE_W-1:0] i_wr_data,
   output logic              o_wr_ack
);
   // elaboration-time parameter checks
   if (HDR_W != NF * FIELD_W) begin : g_bad_hdr
      $error("HDR_W must equal NF*FIELD_W");
   end
   if (NODE_W != 1 + ADDR_W + NF * CUT_W + DIST_W) begin : g_bad_node
      $error("NODE_W does not match the node layout");
   end
   if ((1 << CUT_W) - 1 > FIELD_W) begin : g_bad_cut
      $error("cut count range exceeds field width");
   end
   if (ADDR_W < 1 || DIST_W < 1 || NF < 1) begin : g_bad_size
      $error("widths and field count must be positive");
   end

   // lane-indexed views of the two directions
   logic [NUM_LANES-1:0]             l_in_valid, l_in_leaf, l_in_dir;
   logic [NUM_LANES-1:0][HDR_W-1:0]  l_in_hdr;
   logic [NUM_LANES-1:0][DIST_W-1:0] l_in_dist;
   logic [NUM_LANES-1:0][ADDR_W-1:0] l_in_addr;
   logic [NUM_LANES-1:0]             l_out_valid, l_out_leaf, l_out_dir;
   logic [NUM_LANES-1:0][HDR_W-1:0]  l_out_hdr;
   logic [NUM_LANES-1:0][DIST_W-1:0] l_out_dist;
   logic [NUM_LANES-1:0][ADDR_W-1:0] l_out_addr;
   logic [NUM_LANES-1:0]             l_rd_en;
   logic [NUM_LANES-1:0][ADDR_W-1:0] l_rd_addr;
   logic [NUM_LANES-1:0][NODE_W-1:0] l_rd_node;

   assign l_in_valid = {i_rev_valid, i_fwd_valid};
   assign l_in_leaf  = {i_rev_leaf,  i_fwd_leaf};
   assign l_in_dir   = {i_rev_dir,   i_fwd_dir};
   assign l_in_hdr   = {i_rev_hdr,   i_fwd_hdr};
   assign l_in_dist  = {i_rev_dist,  i_fwd_dist};
   assign l_in_addr  = {i_rev_addr,  i_fwd_addr};

   for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      dtree_lane #(
         .NF(NF), .FIELD_W(FIELD_W), .CUT_W(CUT_W), .ADDR_W(ADDR_W),
         .DIST_W(DIST_W), .HDR_W(HDR_W), .NODE_W(NODE_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (l_in_valid[gl]),
         .in_hdr    (l_in_hdr[gl]),
         .in_dist   (l_in_dist[gl]),
         .in_addr   (l_in_addr[gl]),
         .in_leaf   (l_in_leaf[gl]),
         .in_dir    (l_in_dir[gl]),
         .rd_en     (l_rd_en[gl]),
         .rd_addr   (l_rd_addr[gl]),
         .rd_node   (l_rd_node[gl]),
         .out_valid (l_out_valid[gl]),
         .out_hdr   (l_out_hdr[gl]),
         .out_dist  (l_out_dist[gl]),
         .out_addr  (l_out_addr[gl]),
         .out_leaf  (l_out_leaf[gl]),
         .out_dir   (l_out_dir[gl])
      );
   end

   assign o_fwd_valid = l_out_valid[LANE_UP];
   assign o_fwd_hdr   = l_out_hdr[LANE_UP];
   assign o_fwd_dist  = l_out_dist[LANE_UP];
   assign o_fwd_addr  = l_out_addr[LANE_UP];
   assign o_fwd_leaf  = l_out_leaf[LANE_UP];
   assign o_fwd_dir   = l_out_dir[LANE_UP];
   assign o_rev_valid = l_out_valid[LANE_DOWN];
   assign o_rev_hdr   = l_out_hdr[LANE_DOWN];
   assign o_rev_dist  = l_out_dist[LANE_DOWN];
   assign o_rev_addr  = l_out_addr[LANE_DOWN];
   assign o_rev_leaf  = l_out_leaf[LANE_DOWN];
   assign o_rev_dir   = l_out_dir[LANE_DOWN];

   // write steering: borrow an idle port, rising-order port first
   logic [1:0]             ram_we;
   logic [1:0][ADDR_W-1:0] ram_addr;

   assign ram_we[0] = i_wr_en & ~l_rd_en[LANE_UP];
   assign ram_we[1] = i_wr_en & l_rd_en[LANE_UP] & ~l_rd_en[LANE_DOWN];
   assign o_wr_ack  = |ram_we;

   for (genvar gp = 0; gp < 2; gp++) begin : g_port
      assign ram_addr[gp] = ram_we[gp] ? i_wr_addr : l_rd_addr[gp];
   end

   dtree_dpram #(
      .AW(ADDR_W), .DW(NODE_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .re    (l_rd_en),
      .addr  (ram_addr),
      .wdata (i_wr_data),
      .rdata (l_rd_node)
   );
endmodule

// File: rtl/dtree_stage_chk.sv
module dtree_stage_chk #(
   parameter int NF      = 2,
   parameter int FIELD_W = 8,
   parameter int CUT_W   = 3,
   parameter int ADDR_W  = 6,
   parameter int DIST_W  = 3,
   parameter int HDR_W   = NF * FIELD_W,
   parameter int NODE_W  = 1 + ADDR_W + NF * CUT_W + DIST_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              i_fwd_valid,
   input logic [HDR_W-1:0]  i_fwd_hdr,
   input logic [DIST_W-1:0] i_fwd_dist,
   input logic [ADDR_W-1:0] i_fwd_addr,
   input logic              i_fwd_leaf,
   input logic              i_fwd_dir,
   input logic              i_rev_valid,
   input logic [DIST_W-1:0] i_rev_dist,
   input logic [ADDR_W-1:0] i_rev_addr,
   input logic              i_rev_leaf,
   input logic              o_fwd_valid,
   input logic [HDR_W-1:0]  o_fwd_hdr,
   input logic [DIST_W-1:0] o_fwd_dist,
   input logic [ADDR_W-1:0] o_fwd_addr,
   input logic              o_fwd_dir,
   input logic              o_rev_valid,
   input logic [ADDR_W-1:0] o_rev_addr,
   input logic              o_rev_leaf,
   input logic              i_wr_en,
   input logic              o_wr_ack
);
   // edges seen since reset release, saturating
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age <= 2'd0;
      else if (age != 2'd3)  age <= age + 2'd1;
   end

   logic fwd_rd, rev_rd;
   assign fwd_rd = i_fwd_valid & ~i_fwd_leaf & (i_fwd_dist == '0);
   assign rev_rd = i_rev_valid & ~i_rev_leaf & (i_rev_dist == '0);

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !i_wr_en |-> !o_wr_ack);

   p_lat_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (o_fwd_valid == $past(i_fwd_valid, 2)));

   p_lat_rev_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (o_rev_valid == $past(i_rev_valid, 2)));

   p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(i_fwd_valid && !i_fwd_leaf && i_fwd_dist != '0, 2))
      |-> (o_fwd_dist == DIST_W'($past(i_fwd_dist, 2) - DIST_W'(1))
           && o_fwd_addr == $past(i_fwd_addr, 2)));

   p_leaf_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(i_rev_valid && i_rev_leaf, 2))
      |-> (o_rev_leaf && o_rev_addr == $past(i_rev_addr, 2)));

   p_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(i_fwd_valid, 2))
      |-> (o_fwd_hdr == $past(i_fwd_hdr, 2) && o_fwd_dir == $past(i_fwd_dir, 2)));

   p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (i_wr_en && fwd_rd && rev_rd) |-> !o_wr_ack);

   p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (i_wr_en && !(fwd_rd && rev_rd)) |-> o_wr_ack);
endmodule

bind dtree_stage dtree_stage_chk #(
   .NF(NF), .FIELD_W(FIELD_W), .CUT_W(CUT_W), .ADDR_W(ADDR_W),
   .DIST_W(DIST_W), .HDR_W(HDR_W), .NODE_W(NODE_W)
) u_chk (.*);

// File: tb/dtree_stage_tb.sv
`timescale 1ns/1ps
module dtree_stage_tb;
   localparam int HW = 16;
   localparam int DW = 3;
   localparam int AW = 6;
   localparam int NW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          fv, fl, fd, rv, rl, rd;
   logic [HW-1:0] fh, rh;
   logic [DW-1:0] fdist, rdist;
   logic [AW-1:0] fa, ra;
   logic          ofv, ofl, ofd, orv, orl, ord;
   logic [HW-1:0] ofh, orh;
   logic [DW-1:0] ofdist, ordist;
   logic [AW-1:0] ofa, ora;
   logic          we, ack;
   logic [AW-1:0] wa;
   logic [NW-1:0] wdat;

   dtree_stage u_dut (
      .clk(clk), .rst_n(rst_n),
      .i_fwd_valid(fv), .i_fwd_hdr(fh), .i_fwd_dist(fdist), .i_fwd_addr(fa),
      .i_fwd_leaf(fl), .i_fwd_dir(fd),
      .i_rev_valid(rv), .i_rev_hdr(rh), .i_rev_dist(rdist), .i_rev_addr(ra),
      .i_rev_leaf(rl), .i_rev_dir(rd),
      .o_fwd_valid(ofv), .o_fwd_hdr(ofh), .o_fwd_dist(ofdist), .o_fwd_addr(ofa),
      .o_fwd_leaf(ofl), .o_fwd_dir(ofd),
      .o_rev_valid(orv), .o_rev_hdr(orh), .o_rev_dist(ordist), .o_rev_addr(ora),
      .o_rev_leaf(orl), .o_rev_dir(ord),
      .i_wr_en(we), .i_wr_addr(wa), .i_wr_data(wdat), .o_wr_ack(ack)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] node(input logic leaf, input logic [5:0] base,
                                          input logic [2:0] c0, input logic [2:0] c1,
                                          input logic [2:0] d);
      return {leaf, base, c1, c0, d};
   endfunction

   task automatic idle_in();
      fv = 0; fl = 0; fd = 0; fh = '0; fdist = '0; fa = '0;
      rv = 0; rl = 0; rd = 0; rh = '0; rdist = '0; ra = '0;
      we = 0; wa = '0; wdat = '0;
   endtask

   task automatic set_fwd(input logic [HW-1:0] h, input logic [DW-1:0] d,
                          input logic [AW-1:0] a, input logic lf, input logic dr);
      fv = 1; fh = h; fdist = d; fa = a; fl = lf; fd = dr;
   endtask

   task automatic set_rev(input logic [HW-1:0] h, input logic [DW-1:0] d,
                          input logic [AW-1:0] a, input logic lf, input logic dr);
      rv = 1; rh = h; rdist = d; ra = a; rl = lf; rd = dr;
   endtask

   // after driving at one negedge, wait two edges and land on a negedge
   task automatic settle();
      @(negedge clk); idle_in();
      @(negedge clk);
   endtask

   task automatic write_node(input logic [AW-1:0] a, input logic [NW-1:0] d);
      @(negedge clk);
      we = 1; wa = a; wdat = d;
      #0.5 chk("R10 ack idle", ack, 1);
      @(negedge clk); idle_in();
   endtask

   task automatic t_reset();
      chk("R1 fwd valid", ofv, 0);
      chk("R1 rev valid", orv, 0);
      chk("R1 ack", ack, 0);
   endtask

   task automatic t_skip();
      @(negedge clk); set_fwd(16'hA55A, 3'd3, 6'd5, 0, 0);
      settle();
      chk("R2 valid", ofv, 1);
      chk("R3 dist", ofdist, 2);
      chk("R3 addr", ofa, 5);
      chk("R8 hdr", ofh, 16'hA55A);
      chk("R8 dir", ofd, 0);
   endtask

   task automatic t_read();
      @(negedge clk); set_fwd(16'h80C5, 3'd0, 6'd10, 0, 0);
      settle();
      chk("R4 dist", ofdist, 4);
      chk("R5 child", ofa, 27);
      chk("R4 leaf", ofl, 0);
   endtask

   task automatic t_zero_cut();
      @(negedge clk); set_rev(16'hFFFF, 3'd0, 6'd11, 0, 1);
      settle();
      chk("R5 zero cuts", ora, 40);
      chk("R4 dist rev", ordist, 1);
      chk("R8 dir rev", ord, 1);
      @(negedge clk); set_rev(16'h00FF, 3'd0, 6'd14, 0, 1);
      settle();
      chk("R5 wrap", ora, 1);
   endtask

   task automatic t_leaf_node();
      @(negedge clk); set_fwd(16'h1234, 3'd0, 6'd12, 0, 0);
      settle();
      chk("R6 leaf", ofl, 1);
      chk("R6 ptr", ofa, 33);
      chk("R6 dist", ofdist, 0);
   endtask

   task automatic t_leaf_pass();
      @(negedge clk); set_rev(16'h4321, 3'd0, 6'd10, 1, 1);
      settle();
      chk("R7 leaf", orl, 1);
      chk("R7 addr", ora, 10);
      chk("R7 dist", ordist, 0);
   endtask

   task automatic t_dual_blocked();
      @(negedge clk);
      set_fwd(16'h80C5, 3'd0, 6'd10, 0, 0);
      set_rev(16'h0000, 3'd0, 6'd12, 0, 1);
      we = 1; wa = 6'd50; wdat = node(1, 6'd7, 0, 0, 0);
      #0.5 chk("R10 blocked", ack, 0);
      settle();
      chk("R9 fwd child", ofa, 27);
      chk("R9 rev leaf", orl, 1);
      chk("R9 rev ptr", ora, 33);
   endtask

   task automatic t_write_beside_read();
      @(negedge clk);
      set_fwd(16'h80C5, 3'd0, 6'd10, 0, 0);
      we = 1; wa = 6'd13; wdat = node(1, 6'd45, 0, 0, 0);
      #0.5 chk("R10 share", ack, 1);
      settle();
      chk("R10 read kept", ofa, 27);
      @(negedge clk); set_rev(16'h0000, 3'd0, 6'd13, 0, 1);
      settle();
      chk("R10 visible", ora, 45);
      chk("R10 visible leaf", orl, 1);
   endtask

   task automatic t_stream();
      logic [AW-1:0] ea [3];
      logic [DW-1:0] ed [3];
      ea[0] = 6'd9;  ed[0] = 3'd1;
      ea[1] = 6'd27; ed[1] = 3'd4;
      ea[2] = 6'd33; ed[2] = 3'd0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (i >= 2 && i < 5) begin
            chk("R2 order valid", ofv, 1);
            chk("R2 order addr", ofa, ea[i-2]);
            chk("R2 order dist", ofdist, ed[i-2]);
         end
         if (i == 5) chk("R11 invalid", ofv, 0);
         idle_in();
         if (i == 0) set_fwd(16'h0000, 3'd2, 6'd9, 0, 0);
         if (i == 1) set_fwd(16'h80C5, 3'd0, 6'd10, 0, 0);
         if (i == 2) set_fwd(16'h0000, 3'd0, 6'd12, 0, 0);
         if (i == 3) begin fdist = 3'd5; fa = 6'd3; end
      end
   endtask

   initial begin
      idle_in();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      write_node(6'd10, node(0, 6'd20, 3'd2, 3'd1, 3'd4));
      write_node(6'd11, node(0, 6'd40, 3'd0, 3'd0, 3'd1));
      write_node(6'd12, node(1, 6'd33, 3'd5, 3'd5, 3'd6));
      write_node(6'd14, node(0, 6'd62, 3'd2, 3'd0, 3'd2));
      t_skip();
      t_read();
      t_zero_cut();
      t_leaf_node();
      t_leaf_pass();
      t_dual_blocked();
      t_write_beside_read();
      t_stream();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule